// File: doc/BRIEF.md
# Indirect Bus Window Access Controller

This block lets a host reach a large external address space through four 16-bit registers. The host writes the upper and lower parts of a 27-bit target address, chooses a transfer width and a packing mode, and then touches one of two data ports. Each data port access becomes one or two external bus cycles on a request/acknowledge master port. The read result, or the completion of a write, is returned on the same host access.

Packing can turn one 16-bit host write into two byte cycles (low byte first), or gather two 16-bit host writes into one 32-bit cycle. The second data port can step the address by the number of bytes moved, and the step carries across the split between the two address registers. The first data port never moves the address. Bit 16 of the target address selects the byte-wide half of the external window, and a dedicated output flags it.

The host side uses a valid/ready handshake. The host raises `hst_valid` with its command and holds all command fields steady until it sees `hst_ready`. `hst_ready` is high for exactly one cycle and completes the access. The block applies back-pressure by keeping `hst_ready` low while its external cycles are in flight. There is no queueing, so one access is handled at a time.

Top module: `ibw_ctrl`

## Requirements
- R1: Register index 0 (byte offset 0x0) holds target address bits 26:11. Index 1 (offset 0x2) holds width in bits 15:14, packing in bits 13:12, the step enable in bit 11 and address bits 10:0. Both registers read back what was written, and index 1 also reflects any stepping.
- R2: `hst_ready` is high only while `hst_valid` is high and lasts one cycle. An access that makes no external cycle completes with `hst_ready` in the second cycle after `hst_valid` is first seen.
- R3: In normal packing (code 0 or 2), a write to data index 2 (offset 0x4) makes one cycle at the current address. `ext_size` equals the width code (1 = 32-bit, 2 = 16-bit, 3 = 8-bit). Write data is right-aligned, so byte cycles carry bits 7:0 only. Index 2 never changes the address, whatever the step enable says.
- R4: A normal read returns the external data right-aligned. For byte cycles it returns only bits 7:0, zero-extended.
- R5: With the step enable set, each cycle-launching access to data index 3 (offset 0x6) advances the 27-bit address by 4, 2 or 1 for normal packing and by 2 for split. The step carries from bit 10 into bit 11 and wraps at 2^27.
- R6: With the step enable clear, repeated index 3 accesses use the same address.
- R7: Split packing (code 1) makes two byte cycles: bits 7:0 go to address A, then bits 15:8 go to A+1. A split read returns {byte at A+1, byte at A}.
- R8: Combine packing (code 3) always uses 32-bit cycles. For writes, the first data write makes no cycle and its data is kept as the low half. The second data write launches one cycle with {second, first}. For reads, the first read launches the cycle and returns bits 15:0, and the second read returns bits 31:16 with no cycle. A step applies only on the launching access.
- R9: Width code 0 makes no external cycle, returns 0 on reads and never steps the address.
- R10: `ext_req` stays high, with address, size, direction and write data steady, until `ext_ack` is sampled high. Each acknowledge completes exactly one expected cycle.
- R11: `ext_lane8` equals bit 16 of `ext_addr` on every cycle.
- R12: `hst_ready` is never high while `ext_req` is high.
- R13: A write to index 1 clears the combine phase, so the next combine write is again taken as a low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host command valid |
| hst_ready | output | 1 | Host command accepted and completed |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_idx | input | 2 | Register index (byte offset / 2) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid with hst_ready |
| ext_req | output | 1 | External cycle request |
| ext_ack | input | 1 | External cycle acknowledge |
| ext_we | output | 1 | External cycle direction, 1 = write |
| ext_addr | output | 27 | External byte address |
| ext_size | output | 2 | Width code of the cycle |
| ext_lane8 | output | 1 | Address falls in the byte-wide window half |
| ext_wdata | output | 32 | Right-aligned write data |
| ext_rdata | input | 32 | Right-aligned read data, sampled with ext_ack |

## Verification
The assertions check the handshake rules on every cycle. Host ready must have a valid and lasts one cycle, and ready never overlaps an outstanding external request. A request holds its fields until it is acknowledged, and a request never carries the reserved size. Only the bench's scenarios can show the data path. The bench predicts, with its own model, every cycle's address, size and data, the register readback, the carry and wrap of the address step, the byte order in split mode, and how combine mode pairs its halves, including the phase reset after a configuration write.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
  typedef enum logic [1:0] {
    W_RSV = 2'd0,
    W_32  = 2'd1,
    W_16  = 2'd2,
    W_8   = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    PK_NORM  = 2'd0,
    PK_SPLIT = 2'd1,
    PK_ALT   = 2'd2,
    PK_COMB  = 2'd3
  } pack_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_BEAT1 = 2'd1,
    S_BEAT2 = 2'd2,
    S_RESP  = 2'd3
  } seq_e;
endpackage

// File: rtl/ibw_regs.sv
module ibw_regs
  import ibw_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int LO_W   = 11,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_cfg,
  input  logic [DW-1:0]     wdata,
  input  logic              adv,
  input  logic [2:0]        adv_bytes,
  output logic [ADDR_W-1:0] addr,
  output width_e            width,
  output pack_e             pack,
  output logic              inc,
  output logic [DW-1:0]     hi_rd,
  output logic [DW-1:0]     cfg_rd
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] addr_q;
  width_e            width_q;
  pack_e             pack_q;
  logic              inc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      width_q <= W_RSV;
      pack_q  <= PK_NORM;
      inc_q   <= 1'b0;
    end else if (wr_hi) begin
      addr_q[ADDR_W-1:LO_W] <= wdata[HI_W-1:0];
    end else if (wr_cfg) begin
      width_q            <= width_e'(wdata[DW-1 -: 2]);
      pack_q             <= pack_e'(wdata[DW-3 -: 2]);
      inc_q              <= wdata[LO_W];
      addr_q[LO_W-1:0]   <= wdata[LO_W-1:0];
    end else if (adv) begin
      addr_q <= addr_q + ADDR_W'(adv_bytes);
    end
  end

  assign addr   = addr_q;
  assign width  = width_q;
  assign pack   = pack_q;
  assign inc    = inc_q;
  assign hi_rd  = addr_q[ADDR_W-1:LO_W];
  assign cfg_rd = {width_q, pack_q, inc_q, addr_q[LO_W-1:0]};
endmodule

// File: rtl/ibw_plan.sv
module ibw_plan
  import ibw_pkg::*;
(
  input  width_e     width,
  input  pack_e      pack,
  input  logic       phase,
  input  logic       is_write,
  output logic       launch,
  output logic       two_beats,
  output width_e     beat_size,
  output logic [2:0] nbytes,
  output logic       comb_acc
);
  always_comb begin
    launch    = 1'b0;
    two_beats = 1'b0;
    beat_size = W_8;
    nbytes    = 3'd0;
    comb_acc  = 1'b0;
    if (width != W_RSV) begin
      case (pack)
        PK_SPLIT: begin
          launch    = 1'b1;
          two_beats = 1'b1;
          beat_size = W_8;
          nbytes    = 3'd2;
        end
        PK_COMB: begin
          comb_acc  = 1'b1;
          beat_size = W_32;
          nbytes    = 3'd4;
          launch    = is_write ? phase : !phase;
        end
        default: begin
          launch    = 1'b1;
          beat_size = width;
          case (width)
            W_32:    nbytes = 3'd4;
            W_16:    nbytes = 3'd2;
            default: nbytes = 3'd1;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/ibw_seq.sv
module ibw_seq
  import ibw_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int DW     = 16,
  parameter int EXT_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic [1:0]        hst_idx,
  input  logic [DW-1:0]     hst_wdata,
  output logic              hst_ready,
  output logic [DW-1:0]     hst_rdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              inc,
  input  logic [DW-1:0]     hi_rd,
  input  logic [DW-1:0]     cfg_rd,
  input  logic              launch,
  input  logic              two_beats,
  input  width_e            beat_size,
  input  logic [2:0]        nbytes,
  input  logic              comb_acc,
  output logic              phase,
  output logic              wr_hi,
  output logic              wr_cfg,
  output logic              adv,
  output logic [2:0]        adv_bytes,
  output logic              ext_req,
  input  logic              ext_ack,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [1:0]        ext_size,
  output logic [EXT_DW-1:0] ext_wdata,
  input  logic [EXT_DW-1:0] ext_rdata
);
  seq_e              state;
  logic [DW-1:0]     rdata_q, hold_lo, hold_hi;
  logic              pend_hi, pend_cfg, pend_adv, pend_tog, two_q;
  logic [2:0]        pend_bytes;
  logic [7:0]        hi_byte_q, byte0_q;
  logic              phase_q;
  logic [EXT_DW-1:0] pack_wdata;

  always_comb begin
    case (beat_size)
      W_8:     pack_wdata = EXT_DW'(hst_wdata[7:0]);
      W_32:    pack_wdata = comb_acc ? {hst_wdata, hold_lo} : EXT_DW'(hst_wdata);
      default: pack_wdata = EXT_DW'(hst_wdata);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rdata_q    <= '0;
      hold_lo    <= '0;
      hold_hi    <= '0;
      pend_hi    <= 1'b0;
      pend_cfg   <= 1'b0;
      pend_adv   <= 1'b0;
      pend_tog   <= 1'b0;
      pend_bytes <= '0;
      two_q      <= 1'b0;
      hi_byte_q  <= '0;
      byte0_q    <= '0;
      phase_q    <= 1'b0;
      ext_req    <= 1'b0;
      ext_we     <= 1'b0;
      ext_addr   <= '0;
      ext_size   <= 2'd0;
      ext_wdata  <= '0;
    end else begin
      case (state)
        S_IDLE: if (hst_valid) begin
          pend_hi  <= 1'b0;
          pend_cfg <= 1'b0;
          pend_adv <= 1'b0;
          pend_tog <= 1'b0;
          state    <= S_RESP;
          if (!hst_idx[1]) begin
            rdata_q  <= hst_idx[0] ? cfg_rd : hi_rd;
            pend_hi  <= hst_write && !hst_idx[0];
            pend_cfg <= hst_write && hst_idx[0];
          end else begin
            pend_tog <= comb_acc;
            if (launch) begin
              ext_req    <= 1'b1;
              ext_we     <= hst_write;
              ext_addr   <= addr;
              ext_size   <= beat_size;
              ext_wdata  <= pack_wdata;
              two_q      <= two_beats;
              hi_byte_q  <= hst_wdata[15:8];
              pend_adv   <= hst_idx[0] && inc;
              pend_bytes <= nbytes;
              state      <= S_BEAT1;
            end else if (comb_acc) begin
              if (hst_write) hold_lo <= hst_wdata;
              rdata_q <= hst_write ? '0 : hold_hi;
            end else begin
              rdata_q <= '0;
            end
          end
        end
        S_BEAT1: if (ext_ack) begin
          if (two_q) begin
            ext_addr  <= ext_addr + ADDR_W'(1);
            ext_wdata <= EXT_DW'(hi_byte_q);
            byte0_q   <= ext_rdata[7:0];
            state     <= S_BEAT2;
          end else begin
            ext_req <= 1'b0;
            rdata_q <= (ext_size == W_8) ? DW'(ext_rdata[7:0]) : ext_rdata[DW-1:0];
            if (!ext_we) hold_hi <= ext_rdata[EXT_DW-1 -: DW];
            state   <= S_RESP;
          end
        end
        S_BEAT2: if (ext_ack) begin
          ext_req <= 1'b0;
          rdata_q <= {ext_rdata[7:0], byte0_q};
          state   <= S_RESP;
        end
        default: begin
          state <= S_IDLE;
          if (pend_cfg)      phase_q <= 1'b0;
          else if (pend_tog) phase_q <= !phase_q;
        end
      endcase
    end
  end

  assign hst_ready = (state == S_RESP);
  assign hst_rdata = rdata_q;
  assign wr_hi     = hst_ready && pend_hi;
  assign wr_cfg    = hst_ready && pend_cfg;
  assign adv       = hst_ready && pend_adv;
  assign adv_bytes = pend_bytes;
  assign phase     = phase_q;
endmodule

// File: rtl/ibw_ctrl.sv
module ibw_ctrl
  import ibw_pkg::*;
#(
  parameter int ADDR_W   = 27,
  parameter int LO_W     = 11,
  parameter int DW       = 16,
  parameter int EXT_DW   = 32,
  parameter int WIN8_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic              hst_write,
  input  logic [1:0]        hst_idx,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  output logic              ext_req,
  input  logic              ext_ack,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [1:0]        ext_size,
  output logic              ext_lane8,
  output logic [EXT_DW-1:0] ext_wdata,
  input  logic [EXT_DW-1:0] ext_rdata
);
  logic [ADDR_W-1:0] addr;
  width_e            width, beat_size;
  pack_e             pack;
  logic              inc, launch, two_beats, comb_acc, phase;
  logic              wr_hi, wr_cfg, adv;
  logic [2:0]        nbytes, adv_bytes;
  logic [DW-1:0]     hi_rd, cfg_rd;

  ibw_regs #(.ADDR_W(ADDR_W), .LO_W(LO_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_cfg(wr_cfg),
    .wdata(hst_wdata), .adv(adv), .adv_bytes(adv_bytes), .addr(addr),
    .width(width), .pack(pack), .inc(inc), .hi_rd(hi_rd), .cfg_rd(cfg_rd)
  );

  ibw_plan u_plan (
    .width(width), .pack(pack), .phase(phase), .is_write(hst_write),
    .launch(launch), .two_beats(two_beats), .beat_size(beat_size),
    .nbytes(nbytes), .comb_acc(comb_acc)
  );

  ibw_seq #(.ADDR_W(ADDR_W), .DW(DW), .EXT_DW(EXT_DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
    .hst_idx(hst_idx), .hst_wdata(hst_wdata), .hst_ready(hst_ready),
    .hst_rdata(hst_rdata), .addr(addr), .inc(inc), .hi_rd(hi_rd),
    .cfg_rd(cfg_rd), .launch(launch), .two_beats(two_beats),
    .beat_size(beat_size), .nbytes(nbytes), .comb_acc(comb_acc),
    .phase(phase), .wr_hi(wr_hi), .wr_cfg(wr_cfg), .adv(adv),
    .adv_bytes(adv_bytes), .ext_req(ext_req), .ext_ack(ext_ack),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_size(ext_size),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  assign ext_lane8 = ext_addr[WIN8_BIT];
endmodule

// File: rtl/ibw_chk.sv
module ibw_chk #(
  parameter int ADDR_W = 27,
  parameter int EXT_DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_valid,
  input logic              hst_ready,
  input logic              ext_req,
  input logic              ext_ack,
  input logic              ext_we,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [1:0]        ext_size,
  input logic [EXT_DW-1:0] ext_wdata
);
  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ready |-> hst_valid);

  p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ready |=> !hst_ready);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)
                               && $stable(ext_size) && $stable(ext_wdata)));

  p_no_ready_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !hst_ready);

  p_size_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (ext_size != 2'd0));
endmodule

bind ibw_ctrl ibw_chk #(.ADDR_W(ADDR_W), .EXT_DW(EXT_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_ready(hst_ready),
  .ext_req(ext_req), .ext_ack(ext_ack), .ext_we(ext_we), .ext_addr(ext_addr),
  .ext_size(ext_size), .ext_wdata(ext_wdata)
);

// File: tb/sim_ibw_ctrl.sv
`timescale 1ns/1ps
module sim_ibw_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0, hst_write = 1'b0;
  logic [1:0]  hst_idx = 2'd0;
  logic [15:0] hst_wdata = '0;
  logic        hst_ready;
  logic [15:0] hst_rdata;
  logic        ext_req, ext_we, ext_lane8;
  logic        ext_ack = 1'b0;
  logic [26:0] ext_addr;
  logic [1:0]  ext_size;
  logic [31:0] ext_wdata;
  logic [31:0] ext_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R10 idle";

  always #5 clk = ~clk;

  ibw_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_ready(hst_ready),
    .hst_write(hst_write), .hst_idx(hst_idx), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .ext_req(ext_req), .ext_ack(ext_ack),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_size(ext_size),
    .ext_lane8(ext_lane8), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  // reference model state
  logic [7:0]  mem [logic [26:0]];
  logic [15:0] m_hi = '0, m_hlo = '0, m_hhi = '0;
  logic [10:0] m_lo = '0;
  logic [1:0]  m_w = '0, m_pk = '0;
  logic        m_inc = 1'b0, m_ph = 1'b0;
  logic [26:0] qa[$];
  logic [1:0]  qs[$];
  bit          qw[$];
  logic [31:0] qd[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input logic [26:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] rd16(input logic [26:0] a);
    return {rb(a + 27'd1), rb(a)};
  endfunction

  function automatic int sz_bytes(input logic [1:0] s);
    return (s == 2'd1) ? 4 : (s == 2'd2) ? 2 : 1;
  endfunction

  task automatic push(input logic [26:0] a, input logic [1:0] s, input bit w, input logic [31:0] d);
    qa.push_back(a); qs.push_back(s); qw.push_back(w); qd.push_back(d);
  endtask

  // external responder with per-beat comparison against the model queue
  initial begin
    int cnt = 0, dly = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        ext_ack = 1'b0; cnt = 0;
      end else if (ext_ack) begin
        ext_ack = 1'b0; cnt = 0;
      end else if (ext_req) begin
        if (cnt >= dly) begin
          int n;
          n = sz_bytes(ext_size);
          chk(ext_lane8 == ext_addr[16], "R11 lane flag", {31'd0, ext_lane8}, {31'd0, ext_addr[16]});
          if (qa.size() == 0) begin
            chk(0, {cur_tag, " R10 unexpected cycle"}, {5'd0, ext_addr}, 0);
          end else begin
            logic [26:0] ea; logic [1:0] es; bit ew; logic [31:0] ed;
            ea = qa.pop_front(); es = qs.pop_front(); ew = qw.pop_front(); ed = qd.pop_front();
            chk(ext_addr == ea, {cur_tag, " cycle addr"}, {5'd0, ext_addr}, {5'd0, ea});
            chk(ext_size == es, {cur_tag, " cycle size"}, {30'd0, ext_size}, {30'd0, es});
            chk(ext_we == ew, {cur_tag, " cycle dir"}, {31'd0, ext_we}, {31'd0, ew});
            if (ew) chk(ext_wdata == ed, {cur_tag, " cycle data"}, ext_wdata, ed);
          end
          if (ext_we) begin
            for (int i = 0; i < n; i++) mem[ext_addr + 27'(i)] = ext_wdata[8*i +: 8];
            ext_rdata = 32'hDEAD_BEEF;
          end else begin
            ext_rdata = '0;
            for (int i = 0; i < n; i++) ext_rdata[8*i +: 8] = rb(ext_addr + 27'(i));
          end
          ext_ack = 1'b1;
          dly = (dly + 1) % 3;
        end else begin
          cnt++;
        end
      end
      if (rst_n && hst_ready && ext_req)
        chk(0, "R12 ready during cycle", 1, 0);
    end
  end

  task automatic acc(input bit w, input int idx, input logic [15:0] wd, input string tag);
    logic [26:0] a;
    logic [15:0] exp_rd;
    bit launched;
    int nb, waits;
    a = {m_hi, m_lo};
    exp_rd = '0; launched = 0; nb = 0;
    cur_tag = tag;
    if (idx == 0) begin
      if (w) m_hi = wd; else exp_rd = m_hi;
    end else if (idx == 1) begin
      if (w) begin {m_w, m_pk, m_inc, m_lo} = wd; m_ph = 0; end
      else exp_rd = {m_w, m_pk, m_inc, m_lo};
    end else if (m_w == 2'd0) begin
      exp_rd = '0;
    end else if (m_pk == 2'd1) begin
      push(a, 2'd3, w, {24'd0, wd[7:0]});
      push(a + 27'd1, 2'd3, w, {24'd0, wd[15:8]});
      exp_rd = rd16(a); launched = 1; nb = 2;
    end else if (m_pk == 2'd3) begin
      nb = 4;
      if (w) begin
        if (!m_ph) m_hlo = wd;
        else begin push(a, 2'd1, 1, {wd, m_hlo}); launched = 1; end
      end else begin
        if (!m_ph) begin
          push(a, 2'd1, 0, 0); exp_rd = rd16(a); m_hhi = rd16(a + 27'd2); launched = 1;
        end else exp_rd = m_hhi;
      end
      m_ph = !m_ph;
    end else begin
      nb = sz_bytes(m_w);
      push(a, m_w, w, (nb == 1) ? {24'd0, wd[7:0]} : {16'd0, wd});
      exp_rd = (nb == 1) ? {8'd0, rb(a)} : rd16(a);
      launched = 1;
    end
    if (idx == 3 && m_inc && launched) begin
      a = a + 27'(nb);
      {m_hi, m_lo} = a;
    end

    @(negedge clk);
    hst_valid = 1'b1; hst_write = w; hst_idx = idx[1:0]; hst_wdata = wd;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!hst_ready && waits < 2000);
    if (waits >= 2000) chk(0, {tag, " host access hung"}, 0, 1);
    if (!w) chk(hst_rdata == exp_rd, tag, {16'd0, hst_rdata}, {16'd0, exp_rd});
    if (!launched) chk(waits == 1, {tag, " R2 latency"}, waits, 1);
    @(posedge clk);
    #1 hst_valid = 1'b0;
    chk(qa.size() == 0, {tag, " cycle count"}, qa.size(), 0);
    qa.delete(); qs.delete(); qw.delete(); qd.delete();
  endtask

  task automatic cfgw(input logic [1:0] wc, input logic [1:0] pk, input bit en, input logic [10:0] lo);
    acc(1, 1, {wc, pk, en, lo}, "R1 config write");
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(hst_ready == 1'b0, "R2 reset ready low", {31'd0, hst_ready}, 0);
    chk(ext_req == 1'b0, "R10 reset request low", {31'd0, ext_req}, 0);
    rst_n = 1'b1;

    acc(1, 0, 16'h0012, "R1 upper write");
    cfgw(2'd2, 2'd0, 0, 11'h345);
    acc(0, 0, 0, "R1 upper readback");
    acc(0, 1, 0, "R1 config readback");

    acc(1, 2, 16'hBEEF, "R3 halfword write port4");
    acc(0, 2, 0, "R4 halfword read port4");
    acc(0, 1, 0, "R3 address unchanged");

    cfgw(2'd3, 2'd0, 1, 11'h100);
    acc(1, 2, 16'h12A5, "R3 byte write port4 ignores step");
    acc(0, 2, 0, "R4 byte read zero-extended");
    acc(0, 1, 0, "R3 no step through port4");

    cfgw(2'd1, 2'd0, 0, 11'h200);
    acc(1, 2, 16'h7777, "R3 word write");
    acc(0, 2, 0, "R4 word read low half");

    cfgw(2'd2, 2'd0, 1, 11'h010);
    for (int i = 1; i <= 3; i++) acc(1, 3, 16'(i * 16'h0111), "R5 step by two");
    acc(0, 1, 0, "R5 low address after steps");

    cfgw(2'd1, 2'd0, 1, 11'h7FC);
    acc(1, 3, 16'h4321, "R5 step by four to carry");
    acc(0, 0, 0, "R5 carry into upper register");
    acc(0, 1, 0, "R5 low part after carry");

    acc(1, 0, 16'hFFFF, "R5 upper set to top");
    cfgw(2'd3, 2'd0, 1, 11'h7FF);
    acc(1, 3, 16'h00C3, "R5 byte write at top");
    acc(0, 0, 0, "R5 wrap upper zero");
    acc(0, 1, 0, "R5 wrap low zero");

    acc(1, 0, 16'h0012, "R6 upper restore");
    cfgw(2'd2, 2'd0, 0, 11'h050);
    acc(1, 3, 16'h1111, "R6 first write");
    acc(1, 3, 16'h2222, "R6 same address write");
    acc(0, 3, 0, "R6 read same address");

    cfgw(2'd2, 2'd1, 1, 11'h060);
    acc(1, 3, 16'hA1B2, "R7 split write");
    acc(1, 3, 16'hC3D4, "R7 split write stepped");
    acc(0, 1, 0, "R7 step by two after split");
    cfgw(2'd2, 2'd1, 0, 11'h060);
    acc(0, 2, 0, "R7 split read first pair");
    cfgw(2'd2, 2'd1, 0, 11'h062);
    acc(0, 2, 0, "R7 split read second pair");

    cfgw(2'd1, 2'd3, 1, 11'h080);
    acc(1, 3, 16'h1234, "R8 combine low half");
    acc(1, 3, 16'h5678, "R8 combine launch");
    acc(0, 1, 0, "R8 step after launch");
    cfgw(2'd1, 2'd3, 0, 11'h080);
    acc(0, 2, 0, "R8 combine read low");
    acc(0, 2, 0, "R8 combine read high");

    acc(1, 2, 16'hAAAA, "R13 first half");
    cfgw(2'd1, 2'd3, 0, 11'h090);
    acc(1, 2, 16'hBBBB, "R13 taken as low half");
    acc(1, 2, 16'hCCCC, "R13 launch after reset");
    cfgw(2'd2, 2'd0, 0, 11'h090);
    acc(0, 2, 0, "R13 low half stored");

    cfgw(2'd0, 2'd0, 1, 11'h0A0);
    acc(1, 3, 16'h9999, "R9 reserved width write");
    acc(0, 3, 0, "R9 reserved width read zero");
    acc(0, 1, 0, "R9 no step");

    acc(1, 0, 16'h0020, "R11 upper into byte half");
    cfgw(2'd3, 2'd0, 0, 11'h001);
    acc(1, 2, 16'h005A, "R11 byte-half write");
    acc(0, 2, 0, "R11 byte-half read");

    repeat (5) @(negedge clk);
    summary();
  end
endmodule